// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Peripheral Pin Takeover

This block is one general-purpose I/O port of a small microcontroller. Software sees two byte registers on a simple single-cycle bus: an output latch and a pin direction register. Each pin has its own tri-state control, given as an output value and an output enable toward the pad. Input levels pass through a two-flop synchronizer before any logic uses them.

Two pins can serve a capture/compare timer and two can serve a serial transmitter/receiver. A timer channel takes its pin whenever that channel's two-bit edge/level mode is nonzero. The serial unit takes both of its pins while its enable is high. A pin that a peripheral owns is driven the way the peripheral asks, and the direction register no longer controls it. The direction bit does still choose what a data read returns for that bit: the latch or the synchronized pin level. Software can write the latch while a pin is an input. When the direction bit is later set, the pin then switches straight to the stored value, with no glitch.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the latch and direction registers are all zero, every `pin_oe` bit is low, and a read of the direction register returns 0x00.
- R2: A write to the direction register (address 0x0C, bit 7 = pin 7) sets the register. For a pin with no peripheral owner, direction 1 turns `pin_oe` on with `pin_out` equal to the latch bit, and direction 0 turns `pin_oe` off. Both take effect in the cycle after the write edge.
- R3: A read of the data register (address 0x08) returns, for each bit, the latch bit when its direction bit is 1 and the synchronized pin level when it is 0. A change on `pin_in` shows up in the read after the second rising edge and not after the first.
- R4: The latch can be written whatever the direction. For an unowned pin, `pin_out` presents the latch bit while `pin_oe` is off, so the output enable rising never changes `pin_out`.
- R5: Pin 3 (channel 1) and pin 2 (channel 0) take `pin_out`/`pin_oe` from the timer output and output enable while that channel's mode field is nonzero, whatever the direction bit. With mode 0 the pin is plain GPIO.
- R6: While `ser_en` is high, pin 0 is driven from `ser_tx` with `pin_oe` on, pin 1 has `pin_oe` off whatever the direction, and `ser_rx` gives the synchronized level of pin 1.
- R7: While a peripheral owns a pin, a data read of that bit still selects between the latch and the pin level according to its direction bit.
- R8: When a peripheral releases a pin (mode back to 0 or `ser_en` low), the pin returns at once to direction/latch control.
- R9: A write to any address other than 0x08 or 0x0C changes neither register. A read of any other address, and the read data while `bus_sel` is low or `bus_wr` is high, is 0x00.
- R10: `tmr_in[1:0]` gives the synchronized levels of pins 3 and 2 two edges after `pin_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| tmr_mode | input | 4 | Edge/level mode, two bits per channel, channel 0 in bits 1:0 |
| tmr_out | input | 2 | Timer compare outputs |
| tmr_oe | input | 2 | Timer output enables |
| tmr_in | output | 2 | Synchronized channel pin levels |
| ser_en | input | 1 | Serial unit enable |
| ser_tx | input | 1 | Serial transmit data |
| ser_rx | output | 1 | Synchronized serial receive level |

## Verification
The bench writes a latch bit while the pin is an input, and it samples `pin_out` before and after the direction bit is set. A design that gated the output value with the direction would show a 0-to-1 pulse on the pin the moment it is enabled. It reads back a bit whose pin a peripheral owns, with the direction bit both ways. A design that let ownership choose the read source would return the pin level where the latch was expected. It looks at the synchronizer after exactly one edge and after two. A design with the wrong latency shows the new level too early or too late. It also sets the direction bit on the receive pin during serial use and writes to a neighbouring address. A design that did either wrong would drive against the receive line or corrupt a register.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    typedef enum logic [1:0] {
        ROLE_GPIO   = 2'd0,
        ROLE_TMR    = 2'd1,
        ROLE_SER_RX = 2'd2,
        ROLE_SER_TX = 2'd3
    } pin_role_e;

    // Static role of a pin index given the peripheral bit placement
    function automatic pin_role_e role_of(input int idx, input int tmr_base,
                                          input int tmr_ch, input int rx_bit,
                                          input int tx_bit);
        if (idx >= tmr_base && idx < tmr_base + tmr_ch) return ROLE_TMR;
        if (idx == rx_bit) return ROLE_SER_RX;
        if (idx == tx_bit) return ROLE_SER_TX;
        return ROLE_GPIO;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int                WIDTH     = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 'h08,
    parameter logic [ADDR_W-1:0] DIR_ADDR  = 'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  latch,
    output logic [WIDTH-1:0]  dir
);

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
    } regs_t;

    regs_t st_d, st_q;

    logic wr_data, wr_dir, rd_data, rd_dir;

    always_comb begin
        wr_data = bus_sel &&  bus_wr && (bus_addr == DATA_ADDR);
        wr_dir  = bus_sel &&  bus_wr && (bus_addr == DIR_ADDR);
        rd_data = bus_sel && !bus_wr && (bus_addr == DATA_ADDR);
        rd_dir  = bus_sel && !bus_wr && (bus_addr == DIR_ADDR);
    end

    always_comb begin
        st_d = st_q;
        if (wr_data) st_d.latch = bus_wdata;
        if (wr_dir)  st_d.dir   = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read source per bit follows the direction bit, never ownership
    always_comb begin
        bus_rdata = '0;
        if (rd_data) bus_rdata = (st_q.dir & st_q.latch) | (~st_q.dir & pin_sync);
        else if (rd_dir) bus_rdata = st_q.dir;
    end

    assign latch = st_q.latch;
    assign dir   = st_q.dir;

    // R1: reset leaves both registers cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (st_q == '0));

    // R2: a direction write lands in the next cycle
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir == $past(bus_wdata)));

    // R9: without a data write the latch holds
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(latch));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_mux_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int TMR_CH     = 2,
    parameter int TMR_BASE   = 2,
    parameter int MODE_W     = 2,
    parameter int SER_RX_BIT = 1,
    parameter int SER_TX_BIT = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WIDTH-1:0]         latch,
    input  logic [WIDTH-1:0]         dir,
    input  logic [WIDTH-1:0]         pin_sync,
    input  logic [TMR_CH*MODE_W-1:0] tmr_mode,
    input  logic [TMR_CH-1:0]        tmr_out,
    input  logic [TMR_CH-1:0]        tmr_oe,
    input  logic                     ser_en,
    input  logic                     ser_tx,
    output logic [WIDTH-1:0]         pin_out,
    output logic [WIDTH-1:0]         pin_oe,
    output logic [TMR_CH-1:0]        tmr_in,
    output logic                     ser_rx
);

    logic [WIDTH-1:0] owned;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        localparam pin_role_e ROLE = role_of(i, TMR_BASE, TMR_CH, SER_RX_BIT, SER_TX_BIT);
        if (ROLE == ROLE_TMR) begin : g_tmr
            localparam int CH = i - TMR_BASE;
            assign owned[i]   = |tmr_mode[CH*MODE_W +: MODE_W];
            assign pin_out[i] = owned[i] ? tmr_out[CH] : latch[i];
            assign pin_oe[i]  = owned[i] ? tmr_oe[CH]  : dir[i];
        end else if (ROLE == ROLE_SER_RX) begin : g_rx
            assign owned[i]   = ser_en;
            assign pin_out[i] = owned[i] ? 1'b0 : latch[i];
            assign pin_oe[i]  = owned[i] ? 1'b0 : dir[i];
        end else if (ROLE == ROLE_SER_TX) begin : g_tx
            assign owned[i]   = ser_en;
            assign pin_out[i] = owned[i] ? ser_tx : latch[i];
            assign pin_oe[i]  = owned[i] ? 1'b1   : dir[i];
        end else begin : g_gpio
            assign owned[i]   = 1'b0;
            assign pin_out[i] = latch[i];
            assign pin_oe[i]  = dir[i];
        end

        // R4: enabling an unowned pin never changes its value
        p_oe_rise_no_glitch_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!owned[i] && $past(!owned[i]) && $rose(pin_oe[i])) |-> $stable(pin_out[i]));
    end

    for (genvar c = 0; c < TMR_CH; c++) begin : g_tin
        assign tmr_in[c] = pin_sync[TMR_BASE + c];
    end

    assign ser_rx = pin_sync[SER_RX_BIT];

    // R6: the receive pin is never driven while the serial unit owns it
    p_rx_never_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> !pin_oe[SER_RX_BIT]);

    // R5: an owned timer pin follows the timer enable, not the direction bit
    p_tmr_oe_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_mode[(TMR_CH-1)*MODE_W +: MODE_W] && !dir[TMR_BASE+TMR_CH-1])
            |-> (pin_oe[TMR_BASE+TMR_CH-1] == tmr_oe[TMR_CH-1]));

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
    parameter int                WIDTH      = 8,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h08,
    parameter logic [ADDR_W-1:0] DIR_ADDR   = 'h0C,
    parameter int                SYNC_STAGES = 2,
    parameter int                TMR_CH     = 2,
    parameter int                TMR_BASE   = 2,
    parameter int                MODE_W     = 2,
    parameter int                SER_RX_BIT = 1,
    parameter int                SER_TX_BIT = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WIDTH-1:0]         bus_wdata,
    output logic [WIDTH-1:0]         bus_rdata,
    input  logic [WIDTH-1:0]         pin_in,
    output logic [WIDTH-1:0]         pin_out,
    output logic [WIDTH-1:0]         pin_oe,
    input  logic [TMR_CH*MODE_W-1:0] tmr_mode,
    input  logic [TMR_CH-1:0]        tmr_out,
    input  logic [TMR_CH-1:0]        tmr_oe,
    output logic [TMR_CH-1:0]        tmr_in,
    input  logic                     ser_en,
    input  logic                     ser_tx,
    output logic                     ser_rx
);

    logic [WIDTH-1:0] pin_sync, latch, dir;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(
        .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .latch     (latch),
        .dir       (dir)
    );

    gpio_pin_mux #(
        .WIDTH(WIDTH), .TMR_CH(TMR_CH), .TMR_BASE(TMR_BASE), .MODE_W(MODE_W),
        .SER_RX_BIT(SER_RX_BIT), .SER_TX_BIT(SER_TX_BIT)
    ) mux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch    (latch),
        .dir      (dir),
        .pin_sync (pin_sync),
        .tmr_mode (tmr_mode),
        .tmr_out  (tmr_out),
        .tmr_oe   (tmr_oe),
        .ser_en   (ser_en),
        .ser_tx   (ser_tx),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .tmr_in   (tmr_in),
        .ser_rx   (ser_rx)
    );

endmodule

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic [3:0] tmr_mode = '0;
    logic [1:0] tmr_out = '0, tmr_oe = '0;
    logic [1:0] tmr_in;
    logic       ser_en = 1'b0, ser_tx = 1'b0;
    logic       ser_rx;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mux_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .tmr_mode(tmr_mode), .tmr_out(tmr_out), .tmr_oe(tmr_oe), .tmr_in(tmr_in),
        .ser_en(ser_en), .ser_tx(ser_tx), .ser_rx(ser_rx)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        check("R1 oe after reset", pin_oe, 8'h00);
        bus_read(8'h0C, r);
        check("R1 dir after reset", r, 8'h00);
        bus_write(8'h0C, 8'hFF);
        check("R1 latch after reset", pin_out, 8'h00);
        bus_write(8'h0C, 8'h00);
    endtask

    task automatic t_dir_out();
        logic [7:0] r;
        bus_write(8'h08, 8'hA5);
        bus_write(8'h0C, 8'hF0);
        check("R2 oe follows dir", pin_oe, 8'hF0);
        check("R2 out shows latch", pin_out, 8'hA5);
        bus_read(8'h0C, r);
        check("R2 dir readback", r, 8'hF0);
        bus_write(8'h0C, 8'h00);
        check("R2 oe off", pin_oe, 8'h00);
    endtask

    task automatic t_read_source();
        logic [7:0] r;
        bus_write(8'h08, 8'h0F);
        bus_write(8'h0C, 8'hF0);
        @(negedge clk); pin_in = 8'h3C;
        @(negedge clk);
        bus_read(8'h08, r);
        check("R3 one edge: old pin level", r, 8'h00);
        @(negedge clk);
        bus_read(8'h08, r);
        check("R3 two edges: hi latch lo pin", r, 8'h0C);
        bus_write(8'h0C, 8'h00);
        check("R10 tmr_in synced", {6'h0, tmr_in}, 8'h03);
        pin_in = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_preload();
        logic [7:0] r;
        bus_write(8'h08, 8'h20);
        check("R4 latch held while input, oe off", pin_oe, 8'h00);
        check("R4 out preloaded before enable", pin_out, 8'h20);
        bus_read(8'h08, r);
        check("R4 input read is pin not latch", r, 8'h00);
        bus_write(8'h0C, 8'h20);
        check("R4 first enabled cycle oe", pin_oe, 8'h20);
        check("R4 first enabled cycle value", pin_out, 8'h20);
        bus_write(8'h0C, 8'h00);
    endtask

    task automatic t_timer();
        logic [7:0] r;
        bus_write(8'h08, 8'h00);
        bus_write(8'h0C, 8'h04);
        @(negedge clk);
        tmr_mode = 4'b0100; tmr_out = 2'b10; tmr_oe = 2'b10;
        #1;
        check("R5 ch1 owns pin3 oe", pin_oe, 8'h0C);
        check("R5 ch1 drives pin3", pin_out & 8'h0C, 8'h08);
        tmr_oe = 2'b00;
        #1;
        check("R5 ch1 oe off despite dir", pin_oe, 8'h04);
        tmr_mode = 4'b0101; tmr_oe = 2'b00;
        #1;
        check("R5 ch0 overrides dir bit2", pin_oe, 8'h00);
        pin_in = 8'h04;
        repeat (2) @(negedge clk);
        bus_read(8'h08, r);
        check("R7 owned bit with dir1 reads latch", r & 8'h0C, 8'h00);
        bus_write(8'h0C, 8'h00);
        bus_read(8'h08, r);
        check("R7 owned bit with dir0 reads pin", r & 8'h0C, 8'h04);
        bus_write(8'h0C, 8'h08);
        bus_write(8'h08, 8'h08);
        @(negedge clk);
        tmr_mode = 4'b0000;
        #1;
        check("R8 timer release restores dir", pin_oe, 8'h08);
        check("R8 timer release restores latch", pin_out, 8'h08);
        pin_in = 8'h00; tmr_out = 2'b00;
        bus_write(8'h0C, 8'h00);
        bus_write(8'h08, 8'h00);
    endtask

    task automatic t_serial();
        logic [7:0] r;
        bus_write(8'h0C, 8'h02);
        @(negedge clk);
        ser_en = 1'b1; ser_tx = 1'b1;
        #1;
        check("R6 tx driven rx off", pin_oe & 8'h03, 8'h01);
        check("R6 tx value", pin_out & 8'h01, 8'h01);
        ser_tx = 1'b0;
        #1;
        check("R6 tx value low", pin_out & 8'h01, 8'h00);
        pin_in = 8'h02;
        @(negedge clk);
        check("R6 rx one edge", {7'h0, ser_rx}, 8'h00);
        @(negedge clk);
        check("R6 rx two edges", {7'h0, ser_rx}, 8'h01);
        bus_read(8'h08, r);
        check("R7 rx bit dir1 reads latch", r & 8'h02, 8'h00);
        bus_write(8'h0C, 8'h00);
        bus_read(8'h08, r);
        check("R7 rx bit dir0 reads pin", r & 8'h02, 8'h02);
        ser_en = 1'b0;
        #1;
        check("R8 serial release", pin_oe & 8'h03, 8'h00);
        pin_in = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_decode();
        logic [7:0] r;
        bus_write(8'h08, 8'h5A);
        bus_write(8'h0C, 8'hFF);
        bus_write(8'h0D, 8'h00);
        bus_write(8'h09, 8'h00);
        check("R9 stray write keeps dir", pin_oe, 8'hFF);
        check("R9 stray write keeps latch", pin_out, 8'h5A);
        bus_read(8'h0D, r);
        check("R9 unmapped read", r, 8'h00);
        #1;
        check("R9 idle rdata", bus_rdata, 8'h00);
        bus_write(8'h0C, 8'h80);
        check("R2 bit7 maps to pin7", pin_oe, 8'h80);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_out();
        t_read_source();
        t_preload();
        t_timer();
        t_serial();
        t_decode();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule